// File: doc/BRIEF.md
# Masked-Trigger Sample Capture Buffer

This block watches a narrow data bus on every edge of a sample clock and stays armed until a trigger condition appears. The condition compares the incoming sample, with don't-care bits removed by a mask word, against a trigger word. Once the condition is seen, the block records one sample per clock into a small on-chip memory. When the memory is full, it stops and holds the record until reset.

A display or readout engine then walks the stored record through a registered read port. Three status flags show where the block stands: waiting for the trigger, recording, or holding a completed record. The sample clock can be the clock of the system under test or a free-running clock. Synchronising the inputs to that clock is left to the surrounding logic.

Top module: `trig_capture`

## Requirements
- R1: After a synchronous active-high reset, `armed` is 1, `capturing` is 0 and `full` is 0, and the next recorded sample goes to address 0.
- R2: While armed, on every rising clock edge the block evaluates the match `(din & mask) == trig` using the values present at that edge. A match leads to `capturing`=1 after that edge, or to `full`=1 when DEPTH is 1. No match leaves `armed`=1.
- R3: The sample present at the triggering edge is stored at address 0.
- R4: At each rising edge after the trigger, one sample is stored at the next consecutive address. Samples arriving during capture do not restart or stop the recording.
- R5: The edge that stores address DEPTH-1 sets `full`=1 and clears `capturing`. A record therefore holds exactly DEPTH samples, the triggering sample included.
- R6: While `full` is 1, the stored contents and the flags do not change, whatever `din`, `trig` and `mask` do, until reset.
- R7: While armed, a change of `trig` or `mask` applied between two edges is used at the very next edge.
- R8: `rd_data` shows the entry at the `rd_addr` sampled by the previous rising edge (one clock of latency). Data is meaningful while `full` is 1.
- R9: A mask bit of 0 makes that data bit don't-care. A trigger bit set where the mask bit is 0 can never match, so the block stays armed.
- R10: Exactly one of `armed`, `capturing` and `full` is 1 at any time outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; re-arms the block |
| din | input | DATA_W | Sampled data bus |
| trig | input | DATA_W | Trigger word compared with masked data |
| mask | input | DATA_W | Per-bit enable for the comparison (1 = compare) |
| rd_addr | input | ADDR_W | Read address for the stored record |
| rd_data | output | DATA_W | Registered read data, one clock after the address |
| armed | output | 1 | Waiting for the trigger condition |
| capturing | output | 1 | Recording samples |
| full | output | 1 | Record complete and frozen |

## Verification
The bench builds the block with DATA_W=4 and DEPTH=8. A shallow memory lets a whole record be filled, read back entry by entry and held in a short run. It also puts the last-address boundary (`capturing` still high one edge before `full`) within a few cycles of the trigger. With the 4-bit width, every mask pattern of interest can be set out in a small vector table: all-ones, all-zeros, partial masks and trigger bits outside the mask.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_FULL    = 2'd2
  } cap_state_t;

endpackage

// File: rtl/trig_match.sv
module trig_match #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] trig,
  input  logic [DATA_W-1:0] mask,
  output logic              hit
);

  logic [DATA_W-1:0] bit_ok;

  // per-bit agreement: masked data bit equals the trigger bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign bit_ok[i] = ~((din[i] & mask[i]) ^ trig[i]);
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  output logic              we,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              armed,
  output logic              capturing,
  output logic              full
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  cap_state_t        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              last;

  assign wr_addr = (state_q == ST_ARMED) ? '0 : ptr_q;
  assign last    = (wr_addr == LAST);

  always_comb begin
    we      = 1'b0;
    state_d = state_q;
    ptr_d   = ptr_q;
    unique case (state_q)
      ST_ARMED: begin
        if (hit) begin
          we      = 1'b1;
          state_d = last ? ST_FULL : ST_CAPTURE;
          ptr_d   = last ? '0 : wr_addr + 1'b1;
        end
      end
      ST_CAPTURE: begin
        we      = 1'b1;
        state_d = last ? ST_FULL : ST_CAPTURE;
        ptr_d   = last ? '0 : wr_addr + 1'b1;
      end
      default: begin
        state_d = ST_FULL;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ARMED;
      ptr_q     <= '0;
      armed     <= 1'b1;
      capturing <= 1'b0;
      full      <= 1'b0;
    end else begin
      state_q   <= state_d;
      ptr_q     <= ptr_d;
      armed     <= (state_d == ST_ARMED);
      capturing <= (state_d == ST_CAPTURE);
      full      <= (state_d == ST_FULL);
    end
  end

  // R6: a completed record stays frozen
  p_full_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    full |=> full);

  // R6: no write may reach the memory while holding
  p_no_write_full_r6: assert property (@(posedge clk) disable iff (rst)
    full |-> !we);

  // R2: a match while armed leaves the armed state
  p_trig_leaves_armed_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && hit) |=> (capturing || full));

  // R2: no match while armed keeps the block armed
  p_stay_armed_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !hit) |=> armed);

  // R4: capture only ends in the full state
  p_capture_progress_r4: assert property (@(posedge clk) disable iff (rst)
    capturing |=> (capturing || full));

  // R4: consecutive writes use consecutive addresses
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (we && !last) |=> (we && wr_addr == $past(wr_addr) + 1'b1));

  // R10: exactly one status flag
  p_one_flag_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot({armed, capturing, full}));

endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // simple dual-port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

  // R4: writes stay inside the record
  p_waddr_range_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] trig,
  input  logic [DATA_W-1:0] mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              armed,
  output logic              capturing,
  output logic              full
);

  logic              hit;
  logic              we;
  logic [ADDR_W-1:0] wr_addr;

  trig_match #(.DATA_W(DATA_W)) u_match (
    .din  (din),
    .trig (trig),
    .mask (mask),
    .hit  (hit)
  );

  cap_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .we        (we),
    .wr_addr   (wr_addr),
    .armed     (armed),
    .capturing (capturing),
    .full      (full)
  );

  cap_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (wr_addr),
    .wdata (din),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R8/R6: with the record frozen and the address held, read data is steady
  p_rd_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (full && $past(full) && $stable(rd_addr)) |=> $stable(rd_data));

endmodule

// File: tb/trig_capture_bench.sv
module trig_capture_bench;

  localparam int DW    = 4;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0, trig = '0, mask = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          armed, capturing, full;

  int total = 0;
  int bad   = 0;

  always #4ns clk = ~clk;   // 125 MHz

  trig_capture #(.DATA_W(DW), .DEPTH(DEPTH)) u_trig_capture (
    .clk(clk), .rst(rst), .din(din), .trig(trig), .mask(mask),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .armed(armed), .capturing(capturing), .full(full)
  );

  // {mask, trig, din, expected hit}
  localparam logic [12:0] VEC [8] = '{
    {4'hF, 4'h5, 4'h5, 1'b1},
    {4'hF, 4'h5, 4'h4, 1'b0},
    {4'h0, 4'h0, 4'hA, 1'b1},   // all don't-care
    {4'h3, 4'h1, 4'hD, 1'b1},
    {4'h3, 4'h1, 4'hE, 1'b0},
    {4'h3, 4'h4, 4'h4, 1'b0},   // trigger bit outside the mask
    {4'hC, 4'h8, 4'hB, 1'b1},
    {4'h8, 4'h8, 4'h7, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [DW-1:0] d);
    din = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [DW-1:0] exp, string req);
    rd_addr = AW'(a);
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 3 + 1) & 4'hF);
  endfunction

  initial begin
    #(8ns * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state
    check("R1 armed", armed, 1);
    check("R1 capturing", capturing, 0);
    check("R1 full", full, 0);

    // R2/R9: table of masked comparisons
    foreach (VEC[k]) begin
      do_reset();
      mask = VEC[k][12:9];
      trig = VEC[k][8:5];
      step(VEC[k][4:1]);
      check("R2 R9 vector capturing", capturing, VEC[k][0]);
      check("R2 R9 vector armed", armed, !VEC[k][0]);
    end

    // Full record: R3, R4, R5, R8
    do_reset();
    mask = 4'hF; trig = 4'h9;
    step(4'h3);
    check("R2 no match stays armed", armed, 1);
    step(4'h9);
    check("R3 capturing after trigger", capturing, 1);
    for (int i = 1; i < DEPTH - 1; i++) begin
      step((pat(i) == 4'h9) ? 4'h0 : pat(i));
      check("R4 still capturing", capturing, 1);
    end
    check("R5 not full before last", full, 0);
    step(pat(DEPTH - 1));
    check("R5 full after last", full, 1);
    check("R5 capturing cleared", capturing, 0);
    check("R10 armed low when full", armed, 0);
    rd_chk(0, 4'h9, "R3 trigger sample at 0");
    for (int i = 1; i < DEPTH; i++)
      rd_chk(i, (pat(i) == 4'h9 && i < DEPTH - 1) ? 4'h0 : pat(i), "R4 R8 readback");

    // R6: hold while full, matching stimulus applied
    mask = 4'h0; trig = 4'h0;
    for (int i = 0; i < 4; i++) step(4'hF - 4'(i));
    check("R6 full held", full, 1);
    check("R6 capturing stays low", capturing, 0);
    rd_chk(0, 4'h9, "R6 entry 0 held");
    rd_chk(DEPTH - 1, pat(DEPTH - 1), "R6 last entry held");

    // R1: reset from full re-arms
    do_reset();
    check("R1 re-armed", armed, 1);
    check("R1 full cleared", full, 0);

    // R7: trigger word change used at the next edge
    mask = 4'hF; trig = 4'h2;
    step(4'h5);
    check("R7 old trig no match", armed, 1);
    trig = 4'h5;
    step(4'h5);
    check("R7 new trig matched", capturing, 1);
    for (int i = 1; i < DEPTH; i++) step(4'h6);
    check("R7 record full", full, 1);
    rd_chk(0, 4'h5, "R7 trigger sample stored");
    rd_chk(1, 4'h6, "R4 following sample");

    // R7: mask change used at the next edge
    do_reset();
    mask = 4'hF; trig = 4'h0;
    step(4'h8);
    check("R7 mask before change", armed, 1);
    mask = 4'h7;
    step(4'h8);
    check("R7 mask after change", capturing, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule